// File: doc/BRIEF.md
# Serial Converter Frame Controller

This block is the device-side serial port and sampling sequencer of a multichannel successive-approximation converter. It brings chip select, frame sync, serial clock, serial data in and an active-low external start strobe into the system clock domain and finds their edges there. From those edges it works out when an operation cycle begins, in one of two framing modes, and counts serial clocks within the cycle. It captures a 4-bit command from the first serial data bits and shifts the previous conversion result out on the serial data output.

The external start strobe drives the sample/convert sequence of an abstract conversion core. The strobe's low time is the sampling window. Its rising edge starts a conversion, and the block holds busy until the core reports done. A strobe that arrives too early in a cycle, or while a conversion is still running, is refused and recorded in an error flag.

Top module: `sadc_frame_ctrl`

## Requirements
- R1: While chip select (`cs_n`) is high, `sdo_oe` is 0, `frame_active` is 0, serial clock edges advance nothing, and serial data in produces no command (`cmd_valid` stays low).
- R2: If `fsync` is 1 when `cs_n` falls, the operation cycle starts on that falling edge: `frame_active` goes to 1 and `sdo_oe` goes to 1.
- R3: If `fsync` is 0 when `cs_n` falls, `frame_active` stays 0 and serial clocks are ignored until `fsync` rises while `cs_n` is low. The cycle starts on that rise.
- R4: The first four `sdi` bits of a cycle are taken on `sclk` rising edges, MSB first. After the fourth bit, `cmd_valid` pulses once, `cmd_chan` equals bits 3..1 of the nibble, and `cmd_mode` equals bit 0.
- R5: During a cycle, `sdo` presents the previous conversion result MSB first. The first bit is valid from the cycle start, and the output moves to the next bit on each `sclk` falling edge.
- R6: A falling edge on `start_n` is accepted only after the 11th `sclk` rising edge of the current cycle. An accepted fall raises `sampling`. The next `start_n` rise clears `sampling`, pulses `conv_start` for one cycle, and raises `busy`.
- R7: `busy` stays 1 from `conv_start` until the cycle in which `conv_done` is seen. `conv_data` is then kept as the result for the next cycle's `sdo`.
- R8: A `start_n` fall before the 11th `sclk` rising edge of the cycle leaves `sampling` and `busy` at 0 and sets `strobe_err`. `strobe_err` stays set until reset.
- R9: A `start_n` fall while `busy` is 1 is ignored: `busy` continues, `sampling` stays 0, and `strobe_err` is set.
- R10: Once a cycle has passed its 11th `sclk` rising edge, the strobe is accepted whatever the levels of `cs_n` and `fsync`, including after `cs_n` has returned high.
- R11: After reset, `frame_active`, `sdo_oe`, `cmd_valid`, `sampling`, `busy`, `conv_start` and `strobe_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| fsync | input | 1 | Frame sync, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in |
| start_n | input | 1 | External sample/convert strobe, active low |
| conv_done | input | 1 | Conversion core finished |
| conv_data | input | RES_W | Result from the conversion core |
| sdo | output | 1 | Serial data out, high impedance when disabled |
| sdo_oe | output | 1 | Serial data out drive enable |
| frame_active | output | 1 | Operation cycle in progress |
| cmd_valid | output | 1 | One-cycle pulse: command nibble captured |
| cmd_chan | output | 3 | Selected channel from the command |
| cmd_mode | output | 1 | Mode bit from the command |
| sampling | output | 1 | Sampling window open |
| conv_start | output | 1 | One-cycle hold/convert-start pulse |
| busy | output | 1 | Conversion in progress |
| strobe_err | output | 1 | Sticky: early or overlapping strobe seen |

## Verification
A table of frames alternates the two framing modes. This separates a cycle started by the chip-select edge from one started by the frame-sync rise, and it shows that clocks sent before that rise are dropped. Each frame uses a different command nibble, and its conversion result is read back in the next frame. All-zero, all-one, single-bit and alternating patterns expose bit-order and shift-edge mistakes. Some frames convert with chip select still low and others after it has risen, which shows the strobe does not depend on the select level. Directed cases send a strobe after 5 clocks (refused) and after the 11th clock (accepted) in the same cycle, and a strobe during busy. Together they tell the lock-out apart from the overlap rule.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int CNT_W   = 4;
    localparam int CHAN_W  = 3;
    localparam int CMD_W   = CHAN_W + 1;

    localparam int IX_CS   = 0;
    localparam int IX_FS   = 1;
    localparam int IX_SCLK = 2;
    localparam int IX_STB  = 3;
    localparam int IX_SDI  = 4;
    localparam int N_ASYNC = 5;

    // idle levels: cs_n high, strobe high, everything else low
    localparam logic [N_ASYNC-1:0] ASYNC_IDLE = 5'b01001;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_CONV
    } strobe_st_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              mode;
    } cmd_t;

    function automatic cmd_t unpack_cmd(input logic [CMD_W-1:0] nib);
        return cmd_t'(nib);
    endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int              W        = 1,
    parameter logic [W-1:0]    IDLE_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= IDLE_VAL[i];
                stab_q <= IDLE_VAL[i];
            end else begin
                meta_q <= din[i];
                stab_q <= meta_q;
            end
        end
        assign lvl[i] = stab_q;
    end
endmodule

// File: rtl/sadc_serial_port.sv
module sadc_serial_port
    import sadc_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int UNLOCK_EDGE = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_lvl,
    input  logic             cs_fall,
    input  logic             fs_lvl,
    input  logic             fs_rise,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             sdi_lvl,
    input  logic [RES_W-1:0] result,
    output logic             active,
    output logic             unlocked,
    output logic             cmd_valid,
    output cmd_t             cmd,
    output logic             sdo_bit,
    output logic             sdo_oe
);
    localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] UNLOCK_IDX = CNT_W'(UNLOCK_EDGE - 1);
    localparam logic [CNT_W-1:0] CNT_MAX    = '1;

    logic             wait_fs;
    logic [CNT_W-1:0] cnt;
    logic [CMD_W-1:0] nib;
    logic [RES_W-1:0] shreg;
    logic             start_now;

    assign start_now = (cs_fall && fs_lvl) || (wait_fs && fs_rise && !cs_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_fs   <= 1'b0;
            active    <= 1'b0;
            cnt       <= '0;
            nib       <= '0;
            shreg     <= '0;
            unlocked  <= 1'b0;
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (cs_lvl) begin
                active  <= 1'b0;
                wait_fs <= 1'b0;
            end else if (start_now) begin
                active   <= 1'b1;
                wait_fs  <= 1'b0;
                cnt      <= '0;
                unlocked <= 1'b0;
                shreg    <= result;
            end else if (cs_fall) begin
                wait_fs <= 1'b1;
                active  <= 1'b0;
                cnt     <= '0;
            end else if (active) begin
                if (sclk_rise) begin
                    if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                    if (cnt <= CMD_LAST) nib <= {nib[CMD_W-2:0], sdi_lvl};
                    if (cnt == CMD_LAST) begin
                        cmd_valid <= 1'b1;
                        cmd       <= unpack_cmd({nib[CMD_W-2:0], sdi_lvl});
                    end
                    if (cnt == UNLOCK_IDX) unlocked <= 1'b1;
                end
                if (sclk_fall) shreg <= {shreg[RES_W-2:0], 1'b0};
            end
        end
    end

    assign sdo_bit = shreg[RES_W-1];
    assign sdo_oe  = !cs_lvl;
endmodule

// File: rtl/sadc_strobe_ctrl.sv
module sadc_strobe_ctrl
    import sadc_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb_fall,
    input  logic             stb_rise,
    input  logic             unlocked,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             sampling,
    output logic             conv_start,
    output logic             busy,
    output logic             strobe_err,
    output logic [RES_W-1:0] result
);
    strobe_st_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            conv_start <= 1'b0;
            strobe_err <= 1'b0;
            result     <= '0;
        end else begin
            conv_start <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (stb_fall) begin
                        if (unlocked) st <= ST_SAMPLE;
                        else          strobe_err <= 1'b1;
                    end
                end
                ST_SAMPLE: begin
                    if (stb_rise) begin
                        st         <= ST_CONV;
                        conv_start <= 1'b1;
                    end
                end
                ST_CONV: begin
                    if (stb_fall) strobe_err <= 1'b1;
                    if (conv_done) begin
                        st     <= ST_IDLE;
                        result <= conv_data;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign sampling = (st == ST_SAMPLE);
    assign busy     = (st == ST_CONV);
endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl
    import sadc_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int UNLOCK_EDGE = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             fsync,
    input  logic             sclk,
    input  logic             sdi,
    input  logic             start_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             frame_active,
    output logic             cmd_valid,
    output logic [2:0]       cmd_chan,
    output logic             cmd_mode,
    output logic             sampling,
    output logic             conv_start,
    output logic             busy,
    output logic             strobe_err
);
    localparam int N_EDGE = 4;

    logic [N_ASYNC-1:0] lvl;
    logic [N_EDGE-1:0]  prv;
    logic cs_lvl, cs_fall, fs_lvl, fs_rise, sclk_rise, sclk_fall, stb_rise, stb_fall;
    logic unlocked, sdo_bit;
    cmd_t cmd;
    logic [RES_W-1:0] result;

    sadc_sync #(.W(N_ASYNC), .IDLE_VAL(ASYNC_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({sdi, start_n, sclk, fsync, cs_n}),
        .lvl (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) prv <= ASYNC_IDLE[N_EDGE-1:0];
        else     prv <= lvl[N_EDGE-1:0];
    end

    assign cs_lvl    = lvl[IX_CS];
    assign cs_fall   = !lvl[IX_CS]  &&  prv[IX_CS];
    assign fs_lvl    = lvl[IX_FS];
    assign fs_rise   = lvl[IX_FS]   && !prv[IX_FS];
    assign sclk_rise = lvl[IX_SCLK] && !prv[IX_SCLK];
    assign sclk_fall = !lvl[IX_SCLK] && prv[IX_SCLK];
    assign stb_rise  = lvl[IX_STB]  && !prv[IX_STB];
    assign stb_fall  = !lvl[IX_STB] &&  prv[IX_STB];

    sadc_serial_port #(.RES_W(RES_W), .UNLOCK_EDGE(UNLOCK_EDGE)) u_port (
        .clk       (clk),
        .rst       (rst),
        .cs_lvl    (cs_lvl),
        .cs_fall   (cs_fall),
        .fs_lvl    (fs_lvl),
        .fs_rise   (fs_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_lvl   (lvl[IX_SDI]),
        .result    (result),
        .active    (frame_active),
        .unlocked  (unlocked),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .sdo_bit   (sdo_bit),
        .sdo_oe    (sdo_oe)
    );

    sadc_strobe_ctrl #(.RES_W(RES_W)) u_stb (
        .clk        (clk),
        .rst        (rst),
        .stb_fall   (stb_fall),
        .stb_rise   (stb_rise),
        .unlocked   (unlocked),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .sampling   (sampling),
        .conv_start (conv_start),
        .busy       (busy),
        .strobe_err (strobe_err),
        .result     (result)
    );

    assign cmd_chan = cmd.chan;
    assign cmd_mode = cmd.mode;
    assign sdo      = sdo_oe ? sdo_bit : 1'bz;
endmodule

// File: rtl/sadc_frame_ctrl_chk.sv
module sadc_frame_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic cs_lvl,
    input logic stb_fall,
    input logic frame_active,
    input logic cmd_valid,
    input logic sampling,
    input logic busy,
    input logic conv_start,
    input logic conv_done,
    input logic strobe_err
);
    // R1
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_lvl |=> !frame_active);

    // R4
    cmd_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> frame_active);

    // R6
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> conv_start);

    // R6
    start_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(sampling));

    // R6
    phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sampling, busy}));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !conv_done |=> busy);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_err |=> strobe_err);

    // R9
    overlap_err_chk: assert property (@(posedge clk) disable iff (rst)
        busy && stb_fall |=> strobe_err && !sampling);
endmodule

bind sadc_frame_ctrl sadc_frame_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_lvl       (cs_lvl),
    .stb_fall     (stb_fall),
    .frame_active (frame_active),
    .cmd_valid    (cmd_valid),
    .sampling     (sampling),
    .busy         (busy),
    .conv_start   (conv_start),
    .conv_done    (conv_done),
    .strobe_err   (strobe_err)
);

// File: tb/sadc_frame_ctrl_tb.sv
module sadc_frame_ctrl_tb;
    localparam int RES_W = 12;
    localparam int NV    = 6;
    // {fsync at cs fall, convert after cs high, command nibble, result}
    localparam logic [17:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'b1011, 12'hA5C},
        {1'b0, 1'b0, 4'b0110, 12'h3F1},
        {1'b1, 1'b1, 4'b1110, 12'h800},
        {1'b0, 1'b1, 4'b0001, 12'h001},
        {1'b1, 1'b0, 4'b0000, 12'hFFF},
        {1'b0, 1'b0, 4'b1111, 12'h5A5}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, fsync = 1'b0, sclk = 1'b0, sdi = 1'b0, start_n = 1'b1;
    logic conv_done = 1'b0;
    logic [RES_W-1:0] conv_data = '0;
    logic sdo, sdo_oe, frame_active, cmd_valid, cmd_mode, sampling, conv_start, busy, strobe_err;
    logic [2:0] cmd_chan;

    int checks = 0, errors = 0, nvalid = 0, nstart = 0;
    logic [RES_W-1:0] prev_res = '0;

    always #5 clk = ~clk;

    sadc_frame_ctrl #(.RES_W(RES_W)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .fsync(fsync), .sclk(sclk), .sdi(sdi),
        .start_n(start_n), .conv_done(conv_done), .conv_data(conv_data),
        .sdo(sdo), .sdo_oe(sdo_oe), .frame_active(frame_active), .cmd_valid(cmd_valid),
        .cmd_chan(cmd_chan), .cmd_mode(cmd_mode), .sampling(sampling),
        .conv_start(conv_start), .busy(busy), .strobe_err(strobe_err)
    );

    always @(posedge clk) begin
        if (cmd_valid)  nvalid++;
        if (conv_start) nstart++;
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sclk_bit(input logic b, output logic got);
        got = sdo;
        sdi = b;
        wclk(2);
        sclk = 1'b1;
        wclk(8);
        sclk = 1'b0;
        wclk(8);
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        fsync = 1'b0;
        wclk(8);
    endtask

    task automatic do_conv(input logic [RES_W-1:0] d, input string tag);
        int s0;
        s0 = nstart;
        start_n = 1'b0;
        wclk(10);
        chk({tag, " R6 sampling open"}, sampling, 1);
        start_n = 1'b1;
        wclk(10);
        chk({tag, " R6 busy after rise"}, {sampling, busy}, 2'b01);
        chk({tag, " R6 one conv_start"}, nstart - s0, 1);
        wclk(20);
        chk({tag, " R7 busy held"}, busy, 1);
        conv_data = d;
        conv_done = 1'b1;
        wclk(1);
        conv_done = 1'b0;
        wclk(3);
        chk({tag, " R7 busy cleared"}, busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic got;
        logic [RES_W-1:0] rd;
        int v0;
        wclk(4);
        rst = 1'b0;
        wclk(4);
        // R11 reset state
        chk("R11 reset outputs", {frame_active, sdo_oe, cmd_valid, sampling, busy, conv_start, strobe_err}, 0);

        // R1: clocks and data while deselected
        v0 = nvalid;
        for (int k = 0; k < 6; k++) sclk_bit(1'b1, got);
        chk("R1 deselected idle", {frame_active, sdo_oe}, 0);
        chk("R1 no command while deselected", nvalid - v0, 0);

        for (int i = 0; i < NV; i++) begin
            logic fsm, late;
            logic [3:0] nib;
            logic [RES_W-1:0] res;
            {fsm, late, nib, res} = VEC[i];
            fsync = fsm;
            wclk(4);
            cs_n = 1'b0;
            wclk(8);
            if (fsm) begin
                chk("R2 cycle starts on cs fall", {frame_active, sdo_oe}, 2'b11);
            end else begin
                chk("R3 no cycle before fsync rise", frame_active, 0);
                v0 = nvalid;
                for (int k = 0; k < 4; k++) sclk_bit(1'b1, got);
                chk("R3 clocks before fsync ignored", {frame_active, nvalid - v0}, 0);
                fsync = 1'b1;
                wclk(8);
                chk("R3 cycle starts on fsync rise", frame_active, 1);
            end
            v0 = nvalid;
            for (int k = 0; k < 16; k++) begin
                sclk_bit(k < 4 ? nib[3-k] : 1'b0, got);
                if (k < RES_W) rd[RES_W-1-k] = got;
            end
            chk("R4 single cmd_valid", nvalid - v0, 1);
            chk("R4 command fields", {cmd_chan, cmd_mode}, {nib[3:1], nib[0]});
            chk("R5 sdo previous result", rd, prev_res);
            if (late) begin
                end_frame();
                do_conv(res, "R10 after deselect");
            end else begin
                do_conv(res, "in frame");
                end_frame();
            end
            prev_res = res;
            chk("R1 sdo released", sdo_oe, 0);
        end
        chk("R9 no error in clean runs", strobe_err, 0);

        // R8: early strobe, then the same cycle unlocks at the 11th edge
        fsync = 1'b1;
        wclk(4);
        cs_n = 1'b0;
        wclk(8);
        for (int k = 0; k < 5; k++) sclk_bit(1'b0, got);
        v0 = nstart;
        start_n = 1'b0;
        wclk(10);
        chk("R8 early strobe not sampled", {sampling, busy}, 0);
        start_n = 1'b1;
        wclk(10);
        chk("R8 early strobe no conversion", {busy, nstart - v0}, 0);
        chk("R8 error flagged", strobe_err, 1);
        for (int k = 0; k < 6; k++) sclk_bit(1'b0, got);
        do_conv(12'h0F0, "R6 after 11th edge");
        end_frame();

        // R9: overlap during busy
        rst = 1'b1;
        wclk(4);
        rst = 1'b0;
        wclk(4);
        chk("R11 error cleared by reset", strobe_err, 0);
        fsync = 1'b1;
        wclk(4);
        cs_n = 1'b0;
        wclk(8);
        for (int k = 0; k < 11; k++) sclk_bit(1'b0, got);
        start_n = 1'b0;
        wclk(10);
        start_n = 1'b1;
        wclk(10);
        chk("R9 busy before overlap", busy, 1);
        v0 = nstart;
        start_n = 1'b0;
        wclk(10);
        chk("R9 overlap ignored", {sampling, busy}, 2'b01);
        chk("R9 overlap flagged", strobe_err, 1);
        start_n = 1'b1;
        wclk(10);
        chk("R9 no second conv_start", nstart - v0, 0);
        conv_done = 1'b1;
        wclk(1);
        conv_done = 1'b0;
        wclk(3);
        chk("R7 done ends busy", busy, 0);
        end_frame();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule